// File: doc/BRIEF.md
# Low-Frequency Real-Time Counter

This block is a slow real-time counter that advances on a 32.768 kHz clock enable. A programmable divider stretches that enable, and each division period moves a 24-bit count forward by one. Four compare channels watch the count, and the block raises sticky event flags for each count step, for the wrap of the count and for each compare match. Any combination of flags can be routed to a single interrupt line.

Software or a neighbouring block drives four single-cycle task strobes: run, halt, zero the count, and preload the count just below its wrap point. A plain valid/write/address port loads the divider value, the compare values and the interrupt enables, clears flags, and reads back every register. Periodic compare events are made by adding a fixed step to a compare value after each match. The 24-bit arithmetic wraps naturally.

Top module: `lp_rtc_top`

## Requirements
- R1: After reset the count, the divider value, all compare values, all flags and all interrupt enables read 0, the counter is halted and `irq` is low.
- R2: While running, the count rises by one on every (P+1)-th `tickEn` pulse, where P is the divider value in 0..4095. Each such step sets flag bit 0 (step event).
- R3: A step from 0xFFFFFF goes to 0x000000 and sets flag bit 1 (wrap event).
- R4: `taskOvf` loads the count with 0xFFFFF0 and raises no event, so the wrap event follows 16 steps later. When it coincides with a step, the load wins and that step is lost.
- R5: `taskClear` zeroes the count and the divider phase and raises no event. It wins over a coincident step and over a coincident `taskOvf`.
- R6: Flag bit 2+i is set when a step moves the count onto compare value i. The flag is set once, not again while the count stays there.
- R7: Compare values may be rewritten at any time. A value formed modulo 2^24, for example an old value plus a step that crosses the wrap, matches after the count wraps.
- R8: Flags stay set until a write to address 2. A written 0 bit clears its flag and a written 1 bit leaves it alone. A flag set by hardware in the same cycle as a clearing write stays set.
- R9: `irq` is high exactly when some flag is set whose enable bit (address 3, same bit positions as the flags) is set.
- R10: `taskStart` runs the counter and `taskStop` halts it. `taskStop` wins if both come in the same cycle. A halted counter holds its count.
- R11: A divider write (address 1) takes effect only while halted and restarts the divider phase. While running the write is ignored.
- R12: A read (`regValid` high, `regWrite` low) returns the following on `regRdata` in the same cycle, zero-extended, and 0 for any other address: address 0 the count, address 1 the divider value, address 2 the flags, address 3 the enables, addresses 4..7 compare values 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle 32.768 kHz tick enable |
| taskStart | input | 1 | Start counting |
| taskStop | input | 1 | Stop counting |
| taskClear | input | 1 | Zero the count, no event |
| taskOvf | input | 1 | Preload count to 0xFFFFF0 |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 4 | Register address |
| regWdata | input | 24 | Write data |
| regRdata | output | 24 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a hardware event sets a flag in the very cycle that software writes 0 to that flag. In the second, a clear or preload task arrives in the cycle where the divider rolls over. Directed sequences line up each collision on purpose: a flag-clearing write placed on a step cycle, and a clear or preload task placed on a step cycle. Random stimulus then repeats both many times. Each cycle is judged by reading the count and flags back through the register port and comparing them with a bench model. In that model the set wins over the clear, and the clear beats the preload, which beats the step.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;

  typedef struct packed {
    logic incr;
    logic clear;
    logic forceOvf;
  } strobe_t;

  localparam int ADDR_W     = 4;
  localparam int ADDR_COUNT = 0;
  localparam int ADDR_PRESC = 1;
  localparam int ADDR_FLAGS = 2;
  localparam int ADDR_INTEN = 3;
  localparam int ADDR_CMP0  = 4;

endpackage

// File: rtl/lp_rtc_cmp.sv
module lp_rtc_cmp #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wdata,
  input  logic             incr,
  input  logic [CNT_W-1:0] nextCount,
  output logic             hit,
  output logic [CNT_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rstN)     value <= '0;
    else if (wrEn) value <= wdata;
  end

  // match only when a step lands on the value
  assign hit = incr && (nextCount == value);

  // R6: a match cannot repeat on the next cycle while the value is unchanged
  p_single_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !wrEn) |=> !hit);

endmodule

// File: rtl/lp_rtc_ctrl.sv
module lp_rtc_ctrl
  import lp_rtc_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             taskStart,
  input  logic             taskStop,
  input  logic             taskClear,
  input  logic             taskOvf,
  input  logic             presWrEn,
  input  logic [PRE_W-1:0] presWdata,
  output logic [PRE_W-1:0] prescVal,
  output strobe_t          strb
);

  logic             running;
  logic [PRE_W-1:0] prescReg;
  logic [PRE_W-1:0] divCnt;
  logic             presAccept;
  logic             rollover;

  assign presAccept = presWrEn && !running;
  assign rollover   = running && tickEn && (divCnt == prescReg);

  always_ff @(posedge clk) begin
    if (!rstN)          running <= 1'b0;
    else if (taskStop)  running <= 1'b0;
    else if (taskStart) running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           prescReg <= '0;
    else if (presAccept) prescReg <= presWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        divCnt <= '0;
    else if (taskClear || presAccept) divCnt <= '0;
    else if (running && tickEn)       divCnt <= rollover ? '0 : divCnt + 1'b1;
  end

  // priority: clear > force-overflow > step
  always_comb begin
    strb.clear    = taskClear;
    strb.forceOvf = taskOvf && !taskClear;
    strb.incr     = rollover && !taskClear && !taskOvf;
  end

  assign prescVal = prescReg;

  // R11: divider value cannot change while running
  p_presc_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(prescReg));

  // R10: no step while halted
  p_halted_no_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !strb.incr);

  // R10: halt wins over start
  p_stop_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    taskStop |=> !running);

endmodule

// File: rtl/lp_rtc_datapath.sv
module lp_rtc_datapath
  import lp_rtc_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int NUM_CC  = 4,
  parameter int OVF_GAP = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [NUM_CC-1:0]            cmpWrEn,
  input  logic                         flagWrEn,
  input  logic                         ienWrEn,
  input  logic [CNT_W-1:0]             wdata,
  output logic [CNT_W-1:0]             count,
  output logic [NUM_CC+1:0]            flags,
  output logic [NUM_CC+1:0]            ien,
  output logic [NUM_CC-1:0][CNT_W-1:0] cmpVals,
  output logic                         irq
);

  localparam int               FLAG_W   = NUM_CC + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] OVF_LOAD = CNT_MAX - CNT_W'(OVF_GAP - 1);

  logic [CNT_W-1:0]  nextCount;
  logic [NUM_CC-1:0] cmpHit;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] flagsKept;

  assign nextCount = count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (strb.clear)    count <= '0;
    else if (strb.forceOvf) count <= OVF_LOAD;
    else if (strb.incr)     count <= nextCount;
  end

  for (genvar i = 0; i < NUM_CC; i++) begin : g_cmp
    lp_rtc_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (cmpWrEn[i]),
      .wdata     (wdata),
      .incr      (strb.incr),
      .nextCount (nextCount),
      .hit       (cmpHit[i]),
      .value     (cmpVals[i])
    );
  end

  assign setVec    = {cmpHit, strb.incr && (count == CNT_MAX), strb.incr};
  assign flagsKept = flagWrEn ? (flags & wdata[FLAG_W-1:0]) : flags;

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsKept | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        ien <= '0;
    else if (ienWrEn) ien <= wdata[FLAG_W-1:0];
  end

  assign irq = |(flags & ien);

  // R5: clear zeroes the count
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0));

  // R5: clear raises no flag
  p_clear_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && !flagWrEn) |=> (flags == $past(flags)));

  // R4: preload value
  p_force_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceOvf |=> (count == OVF_LOAD));

  // R3: wrap goes to zero and sets the wrap flag
  p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incr && count == CNT_MAX) |=> (flags[1] && count == '0));

  // R10: count holds when nothing acts on it
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.incr || strb.clear || strb.forceOvf) |=> $stable(count));

  // R8: a step flag survives a clearing write in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |=> flags[0]);

endmodule

// File: rtl/lp_rtc_top.sv
module lp_rtc_top
  import lp_rtc_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int PRE_W   = 12,
  parameter int NUM_CC  = 4,
  parameter int OVF_GAP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              taskStart,
  input  logic              taskStop,
  input  logic              taskClear,
  input  logic              taskOvf,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic              irq
);

  localparam int FLAG_W = NUM_CC + 2;

  strobe_t                      strb;
  logic                         wrStrobe;
  logic [NUM_CC-1:0]            cmpWrEn;
  logic [PRE_W-1:0]             prescVal;
  logic [CNT_W-1:0]             count;
  logic [FLAG_W-1:0]            flags;
  logic [FLAG_W-1:0]            ien;
  logic [NUM_CC-1:0][CNT_W-1:0] cmpVals;

  assign wrStrobe = regValid && regWrite;

  for (genvar i = 0; i < NUM_CC; i++) begin : g_cmpDec
    assign cmpWrEn[i] = wrStrobe && (regAddr == ADDR_W'(ADDR_CMP0 + i));
  end

  lp_rtc_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .taskStart (taskStart),
    .taskStop  (taskStop),
    .taskClear (taskClear),
    .taskOvf   (taskOvf),
    .presWrEn  (wrStrobe && regAddr == ADDR_W'(ADDR_PRESC)),
    .presWdata (regWdata[PRE_W-1:0]),
    .prescVal  (prescVal),
    .strb      (strb)
  );

  lp_rtc_datapath #(.CNT_W(CNT_W), .NUM_CC(NUM_CC), .OVF_GAP(OVF_GAP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmpWrEn  (cmpWrEn),
    .flagWrEn (wrStrobe && regAddr == ADDR_W'(ADDR_FLAGS)),
    .ienWrEn  (wrStrobe && regAddr == ADDR_W'(ADDR_INTEN)),
    .wdata    (regWdata),
    .count    (count),
    .flags    (flags),
    .ien      (ien),
    .cmpVals  (cmpVals),
    .irq      (irq)
  );

  always_comb begin
    regRdata = '0;
    if (regValid && !regWrite) begin
      if (regAddr == ADDR_W'(ADDR_COUNT)) regRdata = count;
      if (regAddr == ADDR_W'(ADDR_PRESC)) regRdata = CNT_W'(prescVal);
      if (regAddr == ADDR_W'(ADDR_FLAGS)) regRdata = CNT_W'(flags);
      if (regAddr == ADDR_W'(ADDR_INTEN)) regRdata = CNT_W'(ien);
      for (int i = 0; i < NUM_CC; i++) begin
        if (regAddr == ADDR_W'(ADDR_CMP0 + i)) regRdata = cmpVals[i];
      end
    end
  end

  // R12: a write cycle never drives read data
  p_quiet_on_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> (regRdata == '0));

endmodule

// File: tb/test_lp_rtc_top.sv
module test_lp_rtc_top;
  localparam int CW = 24;
  localparam int PW = 12;
  localparam int NC = 4;
  localparam int FW = NC + 2;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic tickEn = 0, taskStart = 0, taskStop = 0, taskClear = 0, taskOvf = 0;
  logic regValid = 0, regWrite = 0;
  logic [3:0] regAddr = '0;
  logic [CW-1:0] regWdata = '0;
  logic [CW-1:0] regRdata;
  logic irq;

  lp_rtc_top i_lp_rtc_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .taskStart(taskStart),
    .taskStop(taskStop), .taskClear(taskClear), .taskOvf(taskOvf),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  int nTests = 0;
  int nFail = 0;

  // reference model
  logic [CW-1:0] mCnt;
  logic [PW-1:0] mPre, mDiv;
  logic          mRun;
  logic [CW-1:0] mCmp [NC];
  logic [FW-1:0] mFlags, mIen;

  function automatic logic [CW-1:0] modelRead(input logic [3:0] a);
    case (a)
      4'd0: return mCnt;
      4'd1: return CW'(mPre);
      4'd2: return CW'(mFlags);
      4'd3: return CW'(mIen);
      4'd4, 4'd5, 4'd6, 4'd7: return mCmp[a - 4'd4];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelReset;
    mCnt = '0; mPre = '0; mDiv = '0; mRun = 1'b0; mFlags = '0; mIen = '0;
    for (int i = 0; i < NC; i++) mCmp[i] = '0;
  endtask

  task automatic modelStep(input logic te, st, sp, cl, ov, v, w,
                           input logic [3:0] a, input logic [CW-1:0] d);
    logic roll, inc, pWr;
    logic [FW-1:0] setV, kept;
    roll = mRun && te && (mDiv == mPre);
    inc  = roll && !cl && !ov;
    pWr  = v && w && (a == 4'd1) && !mRun;
    setV = '0;
    setV[0] = inc;
    setV[1] = inc && (mCnt == MAXV);
    for (int i = 0; i < NC; i++) setV[2+i] = inc && (CW'(mCnt + 1'b1) == mCmp[i]);
    kept = (v && w && a == 4'd2) ? (mFlags & d[FW-1:0]) : mFlags;
    mFlags = kept | setV;
    if (v && w && a == 4'd3) mIen = d[FW-1:0];
    for (int i = 0; i < NC; i++) if (v && w && a == 4'(4 + i)) mCmp[i] = d;
    if (cl || pWr) mDiv = '0;
    else if (mRun && te) mDiv = roll ? '0 : mDiv + 1'b1;
    if (pWr) mPre = d[PW-1:0];
    if (cl) mCnt = '0;
    else if (ov) mCnt = 24'hFFFFF0;
    else if (inc) mCnt = mCnt + 1'b1;
    if (sp) mRun = 1'b0;
    else if (st) mRun = 1'b1;
  endtask

  // one cycle: drive at negedge, check before the edge, advance model
  task automatic cyc(input logic te, st, sp, cl, ov, v, w,
                     input logic [3:0] a, input logic [CW-1:0] d, input string tag);
    tickEn = te; taskStart = st; taskStop = sp; taskClear = cl; taskOvf = ov;
    regValid = v; regWrite = w; regAddr = a; regWdata = d;
    #1;
    if (v && !w) check({tag, " R12 read"}, regRdata, modelRead(a));
    check({tag, " R9 irq"}, CW'(irq), CW'(|(mFlags & mIen)));
    modelStep(te, st, sp, cl, ov, v, w, a, d);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 0, a, '0, tag);
  endtask
  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 1, a, d, tag);
  endtask
  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, '0, '0, tag);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [CW-1:0] cmpv;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, R12 map incl. unmapped address
    for (int a = 0; a < 10; a++) rd(4'(a), "R1 reset");
    check("R1 irq low", CW'(irq), '0);

    // R11 divider write while halted, R2 rate
    wr(4'd1, 24'd2, "R11");
    rd(4'd1, "R11 accept");
    check("R11 value", regRdata, 24'd2);
    cyc(0, 1, 0, 0, 0, 0, 0, '0, '0, "R10 start");
    ticks(9, "R2");
    rd(4'd0, "R2 count");
    check("R2 count after 9 pulses at P=2", modelRead(4'd0), 24'd3);
    rd(4'd2, "R2 step flag");
    wr(4'd1, 24'd5, "R11 ignored write");
    rd(4'd1, "R11 ignored");
    check("R11 held while running", modelRead(4'd1), 24'd2);

    // R10 hold and stop-wins
    cyc(0, 0, 1, 0, 0, 0, 0, '0, '0, "R10 stop");
    ticks(6, "R10 halted");
    rd(4'd0, "R10 hold");
    cyc(0, 1, 1, 0, 0, 0, 0, '0, '0, "R10 both");
    ticks(6, "R10 stop wins");
    rd(4'd0, "R10 stop wins");

    // R4 / R3 preload and wrap, R9 irq
    wr(4'd3, 24'h2, "R9 enable wrap");
    wr(4'd2, 24'h0, "R8 clear all");
    wr(4'd1, 24'd0, "R11 P=0");
    cyc(0, 0, 0, 0, 1, 0, 0, '0, '0, "R4 preload");
    rd(4'd0, "R4 preload value");
    check("R4 preload literal", modelRead(4'd0), 24'hFFFFF0);
    rd(4'd2, "R4 no event");
    cyc(0, 1, 0, 0, 0, 0, 0, '0, '0, "R10 start");
    ticks(15, "R4 approach");
    rd(4'd2, "R3 no wrap yet");
    ticks(1, "R3 wrap");
    rd(4'd0, "R3 wrapped count");
    rd(4'd2, "R3 wrap flag");
    check("R3 wrap flag literal", CW'(mFlags[1]), 24'd1);
    check("R9 irq on", CW'(irq), 24'd1);

    // R5 clear collisions, R4 preload vs step
    ticks(3, "R5 pre");
    cyc(1, 0, 0, 1, 0, 0, 0, '0, '0, "R5 clear vs step");
    rd(4'd0, "R5 count zero");
    cyc(1, 0, 0, 1, 1, 0, 0, '0, '0, "R5 clear vs preload");
    rd(4'd0, "R5 clear wins");
    cyc(1, 0, 0, 0, 1, 0, 0, '0, '0, "R4 preload vs step");
    rd(4'd0, "R4 preload wins");

    // R6 compare once
    wr(4'd2, 24'h0, "R8 clear");
    cyc(0, 0, 0, 1, 0, 0, 0, '0, '0, "R5 clear");
    wr(4'd6, 24'd5, "R6 cmp2");
    ticks(5, "R6 reach");
    cyc(0, 0, 1, 0, 0, 0, 0, '0, '0, "R10 stop");
    rd(4'd2, "R6 cmp flag");
    check("R6 cmp2 flag bit 4", CW'(mFlags[4]), 24'd1);
    wr(4'd2, 24'h0, "R6 clear");
    ticks(4, "R6 held");
    rd(4'd2, "R6 no repeat");

    // R7 modulo compare step
    cyc(0, 0, 0, 0, 1, 0, 0, '0, '0, "R7 preload");
    cmpv = 24'hFFFFF8 + 24'd10;
    wr(4'd4, cmpv, "R7 wrapped cmp");
    cyc(0, 1, 0, 0, 0, 0, 0, '0, '0, "R10 start");
    ticks(19, "R7 run");
    rd(4'd2, "R7 cmp0 flag");
    check("R7 cmp0 flag after wrap", CW'(mFlags[2]), 24'd1);

    // R8 set vs clear same cycle, write 1 keeps
    cyc(1, 0, 0, 0, 0, 1, 1, 4'd2, 24'h0, "R8 collide");
    rd(4'd2, "R8 set wins");
    check("R8 step flag kept", CW'(mFlags[0]), 24'd1);
    wr(4'd2, 24'h3F, "R8 ones");
    rd(4'd2, "R8 ones keep");

    // random phase
    wr(4'd3, 24'h3F, "R9 all enables");
    for (int n = 0; n < 4000; n++) begin
      logic v, w;
      logic [3:0] a;
      logic [CW-1:0] d;
      v = ($urandom % 2) == 0;
      w = v && (($urandom % 4) == 0);
      a = 4'($urandom % 10);
      d = $urandom;
      if (a == 4'd1) d = d % 4;
      if (a >= 4'd4 && a <= 4'd7) d = mCnt + CW'($urandom % 8);
      cyc(($urandom % 2) == 0, ($urandom % 16) == 0, ($urandom % 40) == 0,
          ($urandom % 64) == 0, ($urandom % 48) == 0, v, w, a, d, "R12 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule